// File: doc/BRIEF.md
# Reed–Solomon Error Value Evaluator

This block finds the value of each symbol error in a Reed–Solomon word over GF(2^m). It sits after the syndrome unit and the error-locator solver in a decoder. It takes three kinds of input: up to T error locator numbers, each with a valid flag; the locator polynomial coefficients λ1..λT (λ0 is always 1); and the 2T syndromes S1..S2T. It returns one m-bit error value per lane. The correction stage XORs each value into the symbol at that lane's position.

The block has no clock. It forms the evaluator polynomial Ω(x) = S(x)·Λ(x) mod x^(2T), where S(x) = S1 + S2·x + … . It inverts every locator number in place and evaluates Ω at that inverse. It then divides the result by the formal derivative of Λ at the same point, which only needs the odd-indexed coefficients. The field is fixed by M: M=4 uses x^4+x+1 and M=8 uses x^8+x^4+x^3+x^2+1. Both come with the consecutive roots α^1, α^2, … .

Top module: `rs_fx_evaluator`

## Requirements
- R1: With M=4 and T=4, a word with four errors at distinct positions p gives the injected value on each valid lane. The inputs are: locator α^p, lambda_c[j-1] = λj of Λ(x) = Π(1 + α^p·x), and synd[i-1] = Si = Σ e·α^(i·p). The outputs settle combinationally, with no clock edge.
- R2: With M=8 and T=3, a word with three errors is recovered in the same way.
- R3: A word with ν < T errors is recovered when λ(ν+1)..λT are zero and the unused lanes have their valid flag low.
- R4: A lane whose valid flag is low outputs zero, whatever its locator number.
- R5: When all syndromes are zero, every lane outputs zero.
- R6: A lane at which the derivative term evaluates to zero outputs zero, because the inverse of zero is taken as zero.
- R7: A locator number of zero is inverted to zero. A valid lane carrying it therefore outputs Ω0·(λ1)^-1 = S1·(λ1)^-1.
- R8: Errors at position 0 (locator 1) and at position n-1 (locator α^(n-1)) are recovered for both field sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| loc_num | input | T×M | Error locator number per lane |
| loc_valid | input | T | Lane holds a real error |
| lambda_c | input | T×M | Locator coefficients λ1..λT at index j-1 |
| synd | input | 2T×M | Syndromes S1..S2T at index i-1 |
| err_val | output | T×M | Error value per lane |

## Verification
The main tests use random words that carry exactly T errors. Because each value is checked against what was injected, the whole syndrome, evaluator and derivative chain is exercised. Partial words with ν < T show whether the zero-padded locator terms are handled correctly. Words with errors at positions 0 and n-1 exercise the extreme powers of α. Hand-made inputs cover the rest: a zero locator number, a zero derivative, and all-zero syndromes. These separate the inverse-of-zero convention from the gating done by the valid flag.

// File: rtl/rs_fx_pkg.sv
// Field arithmetic shared by the evaluator. Elements are carried in 8 bits
// and the field size m selects the reduction polynomial; assumes m is 4 or 8.
package rs_fx_pkg;

    // Product of two field elements by shift-and-add with reduction.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b, input int m);
        logic [7:0] acc, sh, msk, poly;
        logic       hi;
        msk  = (m == 4) ? 8'h0F : 8'hFF;
        poly = (m == 4) ? 8'h03 : 8'h1D;
        acc  = 8'h00;
        sh   = a & msk;
        for (int i = 0; i < 8; i++) begin
            if (i < m && b[i]) acc = acc ^ sh;
            hi = (m == 4) ? sh[3] : sh[7];
            sh = (sh << 1) & msk;
            if (hi) sh = sh ^ poly;
        end
        return acc;
    endfunction

    // Inverse as a^(2^m - 2) by repeated squaring; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] a, input int m);
        logic [7:0] p, r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p, m);
            if (i < m) r = gf_mul(r, p, m);
        end
        return (a == 8'h00) ? 8'h00 : r;
    endfunction

endpackage

// File: rtl/rs_fx_omega.sv
// Evaluator polynomial coefficients: omega = S(x)*Lambda(x) mod x^(2T).
// Assumes lambda0 = 1 and coefficients lambda1..lambdaT on lambda_c.
module rs_fx_omega
    import rs_fx_pkg::*;
#(
    parameter int M = 4,
    parameter int T = 4
) (
    input  logic [T-1:0][M-1:0]   lambda_c,
    input  logic [2*T-1:0][M-1:0] synd,
    output logic [2*T-1:0][M-1:0] omega
);
    localparam int NS = 2 * T;

    // Convolution truncated to the low 2T coefficients.
    always_comb begin
        for (int k = 0; k < NS; k++) begin
            omega[k] = synd[k];
            for (int j = 1; j <= T; j++) begin
                if (j <= k)
                    omega[k] = omega[k] ^ M'(gf_mul(8'(lambda_c[j-1]), 8'(synd[k-j]), M));
            end
        end
    end
endmodule

// File: rtl/rs_fx_eval.sv
// Horner evaluation of a polynomial with N coefficients at one point.
// With ODD_ONLY set, only coefficients at even array index are kept, which
// for an array holding lambda1..lambdaN yields the formal derivative.
module rs_fx_eval
    import rs_fx_pkg::*;
#(
    parameter int M        = 4,
    parameter int N        = 8,
    parameter bit ODD_ONLY = 1'b0
) (
    input  logic [N-1:0][M-1:0] coef,
    input  logic [M-1:0]        pt,
    output logic [M-1:0]        value
);
    // Highest coefficient first, one multiply-add per term.
    always_comb begin
        value = '0;
        for (int k = N - 1; k >= 0; k--) begin
            value = M'(gf_mul(8'(value), 8'(pt), M));
            if (!ODD_ONLY || (k % 2 == 0)) value = value ^ coef[k];
        end
    end
endmodule

// File: rtl/rs_fx_lane.sv
// One error lane: inverts its locator number, evaluates omega and the
// derivative there, and divides. Assumes omega is already truncated.
module rs_fx_lane
    import rs_fx_pkg::*;
#(
    parameter int M = 4,
    parameter int T = 4
) (
    input  logic [M-1:0]          loc,
    input  logic                  valid,
    input  logic [2*T-1:0][M-1:0] omega,
    input  logic [T-1:0][M-1:0]   lambda_c,
    output logic [M-1:0]          value,
    output logic [M-1:0]          inv_loc,
    output logic [M-1:0]          num,
    output logic [M-1:0]          den
);
    logic [M-1:0] den_inv;

    // Evaluation point is the inverse of the locator number.
    always_comb inv_loc = M'(gf_inv(8'(loc), M));

    rs_fx_eval #(.M(M), .N(2*T), .ODD_ONLY(1'b0)) u_num (
        .coef(omega), .pt(inv_loc), .value(num)
    );

    rs_fx_eval #(.M(M), .N(T), .ODD_ONLY(1'b1)) u_den (
        .coef(lambda_c), .pt(inv_loc), .value(den)
    );

    // Quotient, gated by the lane's valid flag.
    always_comb begin
        den_inv = M'(gf_inv(8'(den), M));
        value   = valid ? M'(gf_mul(8'(num), 8'(den_inv), M)) : '0;
    end
endmodule

// File: rtl/rs_fx_evaluator.sv
// Combinational Reed-Solomon error value unit over GF(2^M), M in {4, 8}.
// Builds omega once and evaluates T lanes in parallel; no clock or reset.
module rs_fx_evaluator
    import rs_fx_pkg::*;
#(
    parameter int M = 4,
    parameter int T = 4
) (
    input  logic [T-1:0][M-1:0]   loc_num,
    input  logic [T-1:0]          loc_valid,
    input  logic [T-1:0][M-1:0]   lambda_c,
    input  logic [2*T-1:0][M-1:0] synd,
    output logic [T-1:0][M-1:0]   err_val
);
    logic [2*T-1:0][M-1:0] omega;
    logic [T-1:0][M-1:0]   lane_inv;
    logic [T-1:0][M-1:0]   lane_num;
    logic [T-1:0][M-1:0]   lane_den;

    rs_fx_omega #(.M(M), .T(T)) u_omega (
        .lambda_c(lambda_c), .synd(synd), .omega(omega)
    );

    for (genvar g = 0; g < T; g++) begin : g_lane
        rs_fx_lane #(.M(M), .T(T)) u_lane (
            .loc(loc_num[g]), .valid(loc_valid[g]), .omega(omega),
            .lambda_c(lambda_c), .value(err_val[g]), .inv_loc(lane_inv[g]),
            .num(lane_num[g]), .den(lane_den[g])
        );
    end
endmodule

// File: rtl/rs_fx_eval_chk.sv
// Checker for rs_fx_evaluator: relates lane outputs to the evaluated
// numerator, derivative and inverted locator. Purely combinational checks.
module rs_fx_eval_chk
    import rs_fx_pkg::*;
#(
    parameter int M = 4,
    parameter int T = 4
) (
    input logic [T-1:0][M-1:0]   loc_num,
    input logic [T-1:0]          loc_valid,
    input logic [2*T-1:0][M-1:0] synd,
    input logic [T-1:0][M-1:0]   err_val,
    input logic [T-1:0][M-1:0]   lane_inv,
    input logic [T-1:0][M-1:0]   lane_num,
    input logic [T-1:0][M-1:0]   lane_den
);
    // Per-lane relations between separately built pieces.
    always_comb begin
        for (int i = 0; i < T; i++) begin
            if (!loc_valid[i])
                p_gate_r4: assert (err_val[i] == '0);
            if (loc_valid[i] && lane_den[i] != '0)
                p_quotient_r1: assert (M'(gf_mul(8'(err_val[i]), 8'(lane_den[i]), M)) == lane_num[i]);
            if (lane_den[i] == '0)
                p_divzero_r6: assert (err_val[i] == '0);
            if (loc_num[i] == '0)
                p_inv_zero_r7: assert (lane_inv[i] == '0);
            else
                p_inverse_r7: assert (gf_mul(8'(loc_num[i]), 8'(lane_inv[i]), M) == 8'h01);
        end
        if (synd == '0)
            p_quiet_r5: assert (err_val == '0);
    end
endmodule

bind rs_fx_evaluator rs_fx_eval_chk #(.M(M), .T(T)) u_chk (
    .loc_num(loc_num), .loc_valid(loc_valid), .synd(synd), .err_val(err_val),
    .lane_inv(lane_inv), .lane_num(lane_num), .lane_den(lane_den)
);

// File: tb/rs_fx_evaluator_test.sv
// Directed bench: builds words in a log/antilog model, drives two field
// sizes and compares recovered values with the injected ones.
module rs_fx_evaluator_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    logic [3:0][3:0] loc4, lam4;
    logic [3:0]      vld4;
    logic [7:0][3:0] syn4;
    logic [3:0][3:0] out4;
    logic [2:0][7:0] loc8, lam8;
    logic [2:0]      vld8;
    logic [5:0][7:0] syn8;
    logic [2:0][7:0] out8;

    rs_fx_evaluator #(.M(4), .T(4)) uut (
        .loc_num(loc4), .loc_valid(vld4), .lambda_c(lam4), .synd(syn4), .err_val(out4)
    );
    rs_fx_evaluator #(.M(8), .T(3)) uut_wide (
        .loc_num(loc8), .loc_valid(vld8), .lambda_c(lam8), .synd(syn8), .err_val(out8)
    );

    int exp4[0:14], log4[0:15], exp8[0:254], log8[0:255];
    int c_loc[16], c_lam[17], c_syn[32];
    int w_pos[16], w_val[16];

    function automatic int qn(input int m); return (1 << m) - 1; endfunction
    function automatic int bexp(input int e, input int m);
        return (m == 4) ? exp4[e % 15] : exp8[e % 255];
    endfunction
    function automatic int blog(input int a, input int m);
        return (m == 4) ? log4[a] : log8[a];
    endfunction
    function automatic int bmul(input int a, input int b, input int m);
        if (a == 0 || b == 0) return 0;
        return bexp(blog(a, m) + blog(b, m), m);
    endfunction
    function automatic int binv(input int a, input int m);
        return (a == 0) ? 0 : bexp(qn(m) - blog(a, m), m);
    endfunction

    // Antilog tables from the primitive polynomials.
    task automatic build_tables();
        int v = 1;
        for (int i = 0; i < 15; i++) begin
            exp4[i] = v; log4[v] = i;
            v = v << 1; if (v & 16) v = v ^ 19;
        end
        v = 1;
        for (int i = 0; i < 255; i++) begin
            exp8[i] = v; log8[v] = i;
            v = v << 1; if (v & 256) v = v ^ 285;
        end
    endtask

    task automatic chk(input string req, input int got, input int expv);
        n_chk++;
        if (got != expv) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    // Random distinct positions and nonzero values in w_pos/w_val.
    task automatic rand_word(input int m, input int nerr);
        for (int j = 0; j < nerr; j++) begin
            bit dup;
            do begin
                w_pos[j] = $urandom_range(qn(m) - 1, 0);
                dup = 1'b0;
                for (int q = 0; q < j; q++) if (w_pos[q] == w_pos[j]) dup = 1'b1;
            end while (dup);
            w_val[j] = $urandom_range(qn(m), 1);
        end
    endtask

    // Locators, locator polynomial and syndromes for w_pos/w_val; drive them.
    task automatic apply_word(input int m, input int t, input int nerr);
        for (int j = 0; j < 17; j++) c_lam[j] = 0;
        c_lam[0] = 1;
        for (int j = 0; j < 16; j++) c_loc[j] = 0;
        for (int j = 0; j < nerr; j++) begin
            c_loc[j] = bexp(w_pos[j], m);
            for (int d = t; d >= 1; d--) c_lam[d] = c_lam[d] ^ bmul(c_lam[d-1], c_loc[j], m);
        end
        for (int i = 1; i <= 2 * t; i++) begin
            c_syn[i] = 0;
            for (int j = 0; j < nerr; j++)
                c_syn[i] = c_syn[i] ^ bmul(w_val[j], bexp(i * w_pos[j], m), m);
        end
        @(negedge clk);
        for (int j = 0; j < t; j++) begin
            if (m == 4) begin
                loc4[j] = 4'(c_loc[j]); vld4[j] = (j < nerr); lam4[j] = 4'(c_lam[j+1]);
            end else begin
                loc8[j] = 8'(c_loc[j]); vld8[j] = (j < nerr); lam8[j] = 8'(c_lam[j+1]);
            end
        end
        for (int i = 1; i <= 2 * t; i++) begin
            if (m == 4) syn4[i-1] = 4'(c_syn[i]); else syn8[i-1] = 8'(c_syn[i]);
        end
        #2;
    endtask

    task automatic check_word(input string req, input int m, input int t, input int nerr);
        for (int j = 0; j < t; j++)
            chk(req, (m == 4) ? int'(out4[j]) : int'(out8[j]), (j < nerr) ? w_val[j] : 0);
    endtask

    task automatic test_full_r1();
        for (int r = 0; r < 6; r++) begin
            rand_word(4, 4); apply_word(4, 4, 4); check_word("R1", 4, 4, 4);
        end
    endtask

    task automatic test_wide_r2();
        for (int r = 0; r < 6; r++) begin
            rand_word(8, 3); apply_word(8, 3, 3); check_word("R2", 8, 3, 3);
        end
    endtask

    task automatic test_partial_r3();
        for (int nu = 1; nu < 4; nu++) begin
            rand_word(4, nu); apply_word(4, 4, nu); check_word("R3", 4, 4, nu);
        end
        rand_word(8, 1); apply_word(8, 3, 1); check_word("R3", 8, 3, 1);
        rand_word(8, 2); apply_word(8, 3, 2); check_word("R3", 8, 3, 2);
    endtask

    task automatic test_gate_r4();
        rand_word(4, 4); apply_word(4, 4, 4);
        @(negedge clk); vld4[1] = 1'b0; vld4[3] = 1'b0; #2;
        chk("R4", int'(out4[1]), 0);
        chk("R4", int'(out4[3]), 0);
        chk("R4", int'(out4[0]), w_val[0]);
        chk("R4", int'(out4[2]), w_val[2]);
    endtask

    task automatic test_quiet_r5();
        @(negedge clk);
        syn4 = '0; loc4 = {4'd3, 4'd7, 4'd9, 4'd12}; vld4 = 4'hF; lam4 = {4'd1, 4'd2, 4'd3, 4'd4};
        syn8 = '0; loc8 = {8'd5, 8'd77, 8'd200}; vld8 = 3'h7; lam8 = {8'd9, 8'd1, 8'd33};
        #2;
        for (int j = 0; j < 4; j++) chk("R5", int'(out4[j]), 0);
        for (int j = 0; j < 3; j++) chk("R5", int'(out8[j]), 0);
    endtask

    task automatic test_divzero_r6();
        rand_word(4, 4); apply_word(4, 4, 4);
        @(negedge clk); lam4 = '0; #2;
        for (int j = 0; j < 4; j++) chk("R6", int'(out4[j]), 0);
    endtask

    task automatic test_zero_loc_r7();
        @(negedge clk);
        loc4 = '0; vld4 = 4'b0001; lam4 = '0; lam4[0] = 4'd5; syn4 = '0; syn4[0] = 4'd9;
        loc8 = '0; vld8 = 3'b001; lam8 = '0; lam8[0] = 8'd143; syn8 = '0; syn8[0] = 8'd61;
        #2;
        chk("R7", int'(out4[0]), bmul(9, binv(5, 4), 4));
        chk("R7", int'(out8[0]), bmul(61, binv(143, 8), 8));
        chk("R7", int'(out4[1]), 0);
    endtask

    task automatic test_edges_r8();
        w_pos[0] = 0; w_pos[1] = 14; w_pos[2] = 5; w_pos[3] = 9;
        w_val[0] = 15; w_val[1] = 1; w_val[2] = 6; w_val[3] = 11;
        apply_word(4, 4, 4); check_word("R8", 4, 4, 4);
        w_pos[0] = 254; w_pos[1] = 0; w_pos[2] = 100;
        w_val[0] = 255; w_val[1] = 128; w_val[2] = 1;
        apply_word(8, 3, 3); check_word("R8", 8, 3, 3);
    endtask

    initial begin
        #(200000 * 8);
        n_err++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        loc4 = '0; lam4 = '0; vld4 = '0; syn4 = '0;
        loc8 = '0; lam8 = '0; vld8 = '0; syn8 = '0;
        build_tables();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        for (int j = 0; j < 4; j++) chk("R5 idle", int'(out4[j]), 0);
        test_full_r1();
        test_wide_r2();
        test_partial_r3();
        test_gate_r4();
        test_quiet_r5();
        test_divzero_r6();
        test_zero_loc_r7();
        test_edges_r8();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule